// File: doc/BRIEF.md
# Fifth-Port Mode and Path Selector

This block settles how the fifth port of a small switch operates. A two-bit strap picks one of three modes: serial PHY mode, nibble-wide PHY mode, or a shared mode. In the shared mode the port is either the internal copper transceiver or an external nibble-wide MAC-side link. In that mode the block chooses between the two paths on its own from their link states, and the copper path always wins when it has link.

The block reports the path it chose. It resolves the link, duplex, speed and flow-control state that the port's MAC consumes. It also drives the direction control for the shared clock and collision pins, a flag that marks serial single-bit data, and the output enable of the port's LED pins.

External status arrives on active-low pins. These pins are brought into the clock domain through a two-stage synchronizer. A new link or path decision is committed only after it has held steady for a programmable number of cycles, so short link glitches do not toggle the path.

Top module: `p4sel_top`

## Requirements
- R1: Mode strap decode: 2'b00 is serial PHY mode, 2'b01 is nibble PHY mode, and 2'b1x is shared mode. `sni_serial` is 1 only in mode 2'b00.
- R2: In shared mode, once the decision is committed, the copper path is selected (`sel_copper`=1) whenever `copper_link` is 1, whatever `ext_link_n` shows.
- R3: In shared mode the external path is selected (`sel_copper`=0) only when `copper_link` is 0 and `ext_link_n` is 0.
- R4: `sel_copper` reads 1 for the copper path and 0 for the external port. Once committed in a PHY mode it reads 0, and `copper_link` has no effect there.
- R5: In the PHY modes (strap bit 1 = 0), `link_up` follows only the inverse of `ext_link_n`.
- R6: When the external path is in use, `ext_dpx_n`=0 gives `full_duplex`=1 and `ext_spd_n`=0 gives `speed_100`=1. On the copper path these two outputs follow `copper_full` and `copper_100`.
- R7: On the copper path `ext_fc_n` is ignored and `flow_ctrl_en` follows `copper_fc`. Otherwise `ext_fc_n`=0 sets `flow_ctrl_en`=1.
- R8: `clk_col_oe` is 1 (clock and collision pins driven) in both PHY modes and 0 (pins are inputs) in shared mode.
- R9: In serial PHY mode `speed_100` is 0 (10 Mbps), whatever `ext_spd_n` shows.
- R10: `led_oe` is 1 when `led_en_strap` is 1, and 0 (LED pins tri-stated) when it is 0.
- R11: External pins pass through two flops. A new link or path value is committed only after it has held for `settle_cycles`+1 consecutive cycles, so a shorter change leaves `link_up` and `sel_copper` unchanged.
- R12: When neither path has link in shared mode, `link_up` is 0 and `sel_copper` keeps its last value.
- R13: During and right after reset, `sel_copper` is 1 and `link_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 2 | Port mode strap |
| led_en_strap | input | 1 | LED drive enable strap |
| settle_cycles | input | SETTLE_W | Stability window for committing a new state |
| copper_link | input | 1 | Internal copper transceiver link |
| copper_full | input | 1 | Copper negotiated full duplex |
| copper_100 | input | 1 | Copper negotiated 100 Mbps |
| copper_fc | input | 1 | Copper negotiated flow control |
| ext_link_n | input | 1 | External link status, active low |
| ext_dpx_n | input | 1 | External duplex, 0 = full |
| ext_spd_n | input | 1 | External speed, 0 = 100 Mbps |
| ext_fc_n | input | 1 | External flow-control enable, active low |
| sel_copper | output | 1 | 1 = copper path, 0 = external port |
| link_up | output | 1 | Resolved link state |
| full_duplex | output | 1 | Resolved duplex |
| speed_100 | output | 1 | Resolved speed |
| flow_ctrl_en | output | 1 | Resolved flow control |
| clk_col_oe | output | 1 | Drive clock/collision pins |
| sni_serial | output | 1 | Serial single-bit data mode |
| led_oe | output | 1 | LED pin output enable |

## Verification
The hardest case to reach from the ports is a link change that is too short to commit while the path choice is being held. The stimulus first commits a copper link under a long stability window. It then drops the copper link for fewer cycles than the window and checks that the link state and the path do not move. After that it drops both links for good and checks that the port reports link down while the previous path stays selected.

// File: rtl/p4sel_pkg.sv
package p4sel_pkg;

    typedef enum logic [1:0] {
        MODE_SERIAL_PHY = 2'd0,
        MODE_NIBBLE_PHY = 2'd1,
        MODE_SHARED     = 2'd2
    } port_mode_e;

    typedef struct packed {
        logic link;
        logic copper;
    } path_t;

    typedef struct packed {
        logic link;
        logic full;
        logic s100;
        logic fc;
    } port_stat_t;

    localparam path_t PATH_RESET = '{link: 1'b0, copper: 1'b1};

    function automatic port_mode_e decode_mode(input logic [1:0] strap);
        if (strap[1])
            return MODE_SHARED;
        else if (strap[0])
            return MODE_NIBBLE_PHY;
        else
            return MODE_SERIAL_PHY;
    endfunction

endpackage

// File: rtl/p4sel_sync.sv
module p4sel_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[i] <= RST_VAL;
                else if (i == 0)
                    stage_q[i] <= d;
                else
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/p4sel_settle.sv
module p4sel_settle
    import p4sel_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] limit,
    input  path_t            cand,
    output path_t            committed
);
    path_t            pend_q;
    path_t            commit_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= PATH_RESET;
            commit_q <= PATH_RESET;
            cnt_q    <= '0;
        end else if (cand != pend_q) begin
            pend_q <= cand;
            cnt_q  <= '0;
        end else if (cnt_q >= limit) begin
            commit_q <= pend_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign committed = commit_q;
endmodule

// File: rtl/p4sel_status.sv
module p4sel_status
    import p4sel_pkg::*;
(
    input  port_mode_e mode,
    input  path_t      committed,
    input  logic       copper_full,
    input  logic       copper_100,
    input  logic       copper_fc,
    input  logic       dpx_n_s,
    input  logic       spd_n_s,
    input  logic       fc_n_s,
    output port_stat_t stat
);
    logic on_copper;

    always_comb begin
        on_copper = (mode == MODE_SHARED) && committed.copper;
        stat.link = committed.link;
        if (on_copper) begin
            stat.full = copper_full;
            stat.s100 = copper_100;
            stat.fc   = copper_fc;
        end else begin
            stat.full = ~dpx_n_s;
            stat.s100 = (mode == MODE_SERIAL_PHY) ? 1'b0 : ~spd_n_s;
            stat.fc   = ~fc_n_s;
        end
    end
endmodule

// File: rtl/p4sel_top.sv
module p4sel_top
    import p4sel_pkg::*;
#(
    parameter int SETTLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_strap,
    input  logic                led_en_strap,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                copper_link,
    input  logic                copper_full,
    input  logic                copper_100,
    input  logic                copper_fc,
    input  logic                ext_link_n,
    input  logic                ext_dpx_n,
    input  logic                ext_spd_n,
    input  logic                ext_fc_n,
    output logic                sel_copper,
    output logic                link_up,
    output logic                full_duplex,
    output logic                speed_100,
    output logic                flow_ctrl_en,
    output logic                clk_col_oe,
    output logic                sni_serial,
    output logic                led_oe
);
    localparam int EXT_W = 4;

    port_mode_e       mode;
    logic [EXT_W-1:0] ext_s;
    logic             ext_link_s;
    path_t            cand;
    path_t            committed;
    port_stat_t       stat;

    assign mode = decode_mode(mode_strap);

    p4sel_sync #(
        .WIDTH  (EXT_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({EXT_W{1'b1}})
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({ext_link_n, ext_dpx_n, ext_spd_n, ext_fc_n}),
        .q  (ext_s)
    );

    assign ext_link_s = ~ext_s[3];

    always_comb begin
        if (mode == MODE_SHARED) begin
            cand.link = copper_link | ext_link_s;
            if (copper_link)
                cand.copper = 1'b1;
            else if (ext_link_s)
                cand.copper = 1'b0;
            else
                cand.copper = committed.copper;
        end else begin
            cand.link   = ext_link_s;
            cand.copper = 1'b0;
        end
    end

    p4sel_settle #(
        .CNT_W(SETTLE_W)
    ) u_settle (
        .clk      (clk),
        .rst      (rst),
        .limit    (settle_cycles),
        .cand     (cand),
        .committed(committed)
    );

    p4sel_status u_status (
        .mode       (mode),
        .committed  (committed),
        .copper_full(copper_full),
        .copper_100 (copper_100),
        .copper_fc  (copper_fc),
        .dpx_n_s    (ext_s[2]),
        .spd_n_s    (ext_s[1]),
        .fc_n_s     (ext_s[0]),
        .stat       (stat)
    );

    assign sel_copper   = committed.copper;
    assign link_up      = stat.link;
    assign full_duplex  = stat.full;
    assign speed_100    = stat.s100;
    assign flow_ctrl_en = stat.fc;
    assign clk_col_oe   = (mode != MODE_SHARED);
    assign sni_serial   = (mode == MODE_SERIAL_PHY);
    assign led_oe       = led_en_strap;
endmodule

// File: rtl/p4sel_checker.sv
module p4sel_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_strap,
    input logic       copper_link,
    input logic       copper_fc,
    input logic       ext_link_s,
    input logic       sel_copper,
    input logic       link_up,
    input logic       speed_100,
    input logic       flow_ctrl_en,
    input logic       clk_col_oe,
    input logic       led_en_strap,
    input logic       led_oe
);
    // R3: a switch to the external path is only committed while copper was down
    p_ext_needs_copper_down_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(sel_copper) && mode_strap[1] && $past(mode_strap[1])) |-> !$past(copper_link));

    // R12: losing link in shared mode keeps the selected path
    p_hold_path_on_drop_r12: assert property (@(posedge clk) disable iff (rst)
        ($fell(link_up) && mode_strap[1] && $past(mode_strap[1])) |-> $stable(sel_copper));

    // R11: a committed link rise needs a link seen on the previous cycle
    p_rise_after_link_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(ext_link_s || (copper_link && mode_strap[1])));

    // R7: on the copper path the external flow-control pin has no say
    p_fc_from_copper_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_strap[1] && sel_copper) |-> (flow_ctrl_en == copper_fc));

    // R9: serial PHY mode never reports 100 Mbps
    p_serial_is_10m_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_strap == 2'b00) |-> !speed_100);

    // R8: pin direction tracks the mode strap
    p_pin_dir_r8: assert property (@(posedge clk) disable iff (rst)
        clk_col_oe == !mode_strap[1]);

    // R10: LED enable follows its strap
    p_led_r10: assert property (@(posedge clk) disable iff (rst)
        led_oe == led_en_strap);
endmodule

bind p4sel_top p4sel_checker u_p4sel_checker (
    .clk         (clk),
    .rst         (rst),
    .mode_strap  (mode_strap),
    .copper_link (copper_link),
    .copper_fc   (copper_fc),
    .ext_link_s  (ext_link_s),
    .sel_copper  (sel_copper),
    .link_up     (link_up),
    .speed_100   (speed_100),
    .flow_ctrl_en(flow_ctrl_en),
    .clk_col_oe  (clk_col_oe),
    .led_en_strap(led_en_strap),
    .led_oe      (led_oe)
);

// File: tb/p4sel_top_bench.sv
module p4sel_top_bench;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode_strap;
    logic          led_en_strap;
    logic [SW-1:0] settle_cycles;
    logic          copper_link, copper_full, copper_100, copper_fc;
    logic          ext_link_n, ext_dpx_n, ext_spd_n, ext_fc_n;
    logic          sel_copper, link_up, full_duplex, speed_100;
    logic          flow_ctrl_en, clk_col_oe, sni_serial, led_oe;

    int n_vec  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    p4sel_top #(.SETTLE_W(SW)) u_p4sel_top (
        .clk(clk), .rst(rst), .mode_strap(mode_strap), .led_en_strap(led_en_strap),
        .settle_cycles(settle_cycles), .copper_link(copper_link),
        .copper_full(copper_full), .copper_100(copper_100), .copper_fc(copper_fc),
        .ext_link_n(ext_link_n), .ext_dpx_n(ext_dpx_n), .ext_spd_n(ext_spd_n),
        .ext_fc_n(ext_fc_n), .sel_copper(sel_copper), .link_up(link_up),
        .full_duplex(full_duplex), .speed_100(speed_100), .flow_ctrl_en(flow_ctrl_en),
        .clk_col_oe(clk_col_oe), .sni_serial(sni_serial), .led_oe(led_oe)
    );

    // stimulus: mode[2] cu ext_n dpx_n spd_n fc_n cu_full cu_100 cu_fc (10 bits)
    // expected: sel link full s100 fc oe sni (7 bits)
    localparam int NV = 9;
    localparam logic [16:0] VEC [NV] = '{
        17'b10_1_1_1_1_1_1_1_1__1_1_1_1_1_0_0, // R2 copper up, ext down
        17'b11_1_0_0_0_0_0_0_0__1_1_0_0_0_0_0, // R2 R7 copper beats ext, fc pin ignored
        17'b10_0_0_0_0_0_0_0_0__0_1_1_1_1_0_0, // R3 R6 external path, full/100/fc
        17'b10_0_0_1_1_1_1_1_1__0_1_0_0_0_0_0, // R6 R7 external half/10/no fc
        17'b10_0_1_1_1_1_1_1_1__0_0_0_0_0_0_0, // R12 no link, path held
        17'b01_1_0_0_0_0_1_1_1__0_1_1_1_1_1_0, // R4 R5 nibble PHY, copper ignored
        17'b01_1_1_1_1_1_1_1_1__0_0_0_0_0_1_0, // R5 nibble PHY link down
        17'b00_0_0_0_0_0_0_0_0__0_1_1_0_1_1_1, // R1 R9 serial PHY forced 10M
        17'b11_1_0_1_1_1_1_0_1__1_1_1_0_1_0_0  // R2 R6 back to copper values
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_strap = 2'b10; led_en_strap = 1'b1; settle_cycles = 8'd3;
        copper_link = 1'b0; copper_full = 1'b0; copper_100 = 1'b0; copper_fc = 1'b0;
        ext_link_n = 1'b1; ext_dpx_n = 1'b1; ext_spd_n = 1'b1; ext_fc_n = 1'b1;
        wait_cycles(3);
        // R13 reset state
        check("R13", "sel_copper in reset", sel_copper, 1'b1);
        check("R13", "link_up in reset", link_up, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R13", "link_up after reset", link_up, 1'b0);

        for (int v = 0; v < NV; v++) begin
            {mode_strap, copper_link, ext_link_n, ext_dpx_n, ext_spd_n, ext_fc_n,
             copper_full, copper_100, copper_fc} = VEC[v][16:7];
            wait_cycles(12);
            check("R2/R3/R4", "sel_copper", sel_copper, VEC[v][6]);
            check("R5/R12", "link_up", link_up, VEC[v][5]);
            check("R6", "full_duplex", full_duplex, VEC[v][4]);
            check("R6/R9", "speed_100", speed_100, VEC[v][3]);
            check("R7", "flow_ctrl_en", flow_ctrl_en, VEC[v][2]);
            check("R8", "clk_col_oe", clk_col_oe, VEC[v][1]);
            check("R1", "sni_serial", sni_serial, VEC[v][0]);
        end

        // R11 short copper drop under a long window is ignored
        settle_cycles = 8'd20;
        mode_strap = 2'b10; copper_link = 1'b1; ext_link_n = 1'b1;
        wait_cycles(30);
        check("R11", "link committed", link_up, 1'b1);
        copper_link = 1'b0;
        for (int k = 0; k < 8; k++) begin
            wait_cycles(1);
            check("R11", "link during glitch", link_up, 1'b1);
        end
        copper_link = 1'b1;
        wait_cycles(30);
        check("R11", "link after glitch", link_up, 1'b1);
        check("R11", "path after glitch", sel_copper, 1'b1);

        // R11 external pin: two sync flops plus window of settle+1 cycles
        settle_cycles = 8'd5;
        copper_link = 1'b0; ext_link_n = 1'b0;
        wait_cycles(4);
        check("R11", "external link too early", link_up, 1'b1);
        check("R11", "path too early", sel_copper, 1'b1);
        wait_cycles(12);
        check("R3", "external path taken", sel_copper, 1'b0);

        // R12 both links gone after copper path: held copper selection
        copper_link = 1'b1; ext_link_n = 1'b1;
        wait_cycles(15);
        copper_link = 1'b0;
        wait_cycles(15);
        check("R12", "link down", link_up, 1'b0);
        check("R12", "copper path held", sel_copper, 1'b1);

        // R10 LED enable
        led_en_strap = 1'b0;
        wait_cycles(1);
        check("R10", "led_oe off", led_oe, 1'b0);
        led_en_strap = 1'b1;
        wait_cycles(1);
        check("R10", "led_oe on", led_oe, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule